// File: doc/BRIEF.md
# Masked Priority Interrupt Arbiter

This block picks one winner from a set of normal-type interrupt requests and raises a single interrupt line toward the processor. Each source carries a 4-bit priority. The line is gated by a 5-bit mask threshold. The requests it sees have already been qualified by the surrounding register block: a request counts only if it is pending, enabled and routed to the normal type.

A tree of comparators finds the best request, and the result is stored in a register. When software reads the vector register, the register block pulses a read strobe. In that same cycle the arbiter names the winning source on an acknowledge output, so that the register block can clear that source's pending bit. On the next clock edge the arbiter latches a status word that encodes the winner and its priority. An all-ones status word means no request was active.

Top module: `prio_irq_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, `irq_out` is 0, `status_word` is 32'hFFFF_FFFF and `ack_valid` is 0.
- R2: If no bit of `req_vec` is set, `irq_out` is 0 one cycle later.
- R3: With `mask_lvl` equal to 5'h1F, `irq_out` is 1 one cycle after any bit of `req_vec` is set, regardless of priorities.
- R4: For any other `mask_lvl`, `irq_out` is 1 one cycle later only if some active source has a priority strictly greater than `mask_lvl`; mask values 16 to 30 therefore keep the line low.
- R5: The winner is the active source with the largest priority, where source i's priority is `prio_flat[4*i+3:4*i]`.
- R6: Among active sources sharing the largest priority, the highest-numbered source wins.
- R7: One cycle after `rd_stb` with a winner, `status_word` holds the winning source number zero-extended in bits 31:16, zeros in bits 15:4 and the winner's priority in bits 3:0; it then holds that value until the next strobe.
- R8: One cycle after `rd_stb` with no active source, `status_word` is 32'hFFFF_FFFF and no acknowledge is given.
- R9: `ack_valid` is 1 exactly in a cycle where `rd_stb` is 1 and a winner exists, with `ack_src` giving that winner's number.
- R10: The winner and `irq_out` reflect `req_vec`, `prio_flat` and `mask_lvl` from the previous cycle, not the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vec | input | 64 | Qualified normal requests, one per source |
| prio_flat | input | 256 | Packed 4-bit priorities, source i at bits 4i+3:4i |
| mask_lvl | input | 5 | Priority threshold; 5'h1F disables gating |
| rd_stb | input | 1 | Single-cycle vector register read strobe |
| irq_out | output | 1 | Normal interrupt line |
| status_word | output | 32 | Captured winner and priority, or all ones |
| ack_valid | output | 1 | Clear request for the winning source's pending bit |
| ack_src | output | 6 | Source number to clear when ack_valid is high |

## Verification
The properties assume `rd_stb` is a single-cycle pulse and that the register block clears the acknowledged bit before the next strobe. They also assume the inputs stay steady for at least one edge before a read, so that the registered winner matches the requests. The bench acts as that register block. It drives inputs only on falling edges. After each change it waits one rising edge before reading, and it drops the acknowledged request on the falling edge after the strobe. A queue records the status word each read should produce, and a monitor compares it one cycle after the strobe.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;

    localparam int NUM_SRC = 64;
    localparam int PRIO_W  = 4;
    localparam int MASK_W  = 5;
    localparam int WORD_W  = 32;
    localparam int SRC_LSB = 16;
    localparam int SRC_W   = $clog2(NUM_SRC);
    localparam int LEVELS  = $clog2(NUM_SRC);
    localparam int SRC_FLD = WORD_W - SRC_LSB;

    localparam logic [MASK_W-1:0] MASK_OFF = '1;
    localparam logic [WORD_W-1:0] NO_WINNER = '1;

    typedef struct packed {
        logic              valid;
        logic [SRC_W-1:0]  src;
        logic [PRIO_W-1:0] prio;
    } win_t;

    // hi always covers higher source numbers than lo, so >= hands ties upward
    function automatic win_t pick(win_t lo, win_t hi);
        if (!hi.valid)
            return lo;
        if (!lo.valid)
            return hi;
        if (hi.prio >= lo.prio)
            return hi;
        return lo;
    endfunction

endpackage

// File: rtl/prio_tree.sv
module prio_tree
    import prio_arb_pkg::*;
(
    input  logic [NUM_SRC-1:0]        req,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output win_t                      best
);

    win_t leaf [NUM_SRC];

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_leaf
            assign leaf[i] = '{valid: req[i],
                               src:   SRC_W'(i),
                               prio:  prio_flat[i*PRIO_W +: PRIO_W]};
        end
    endgenerate

    // pairwise reduction, level by level, in place
    always_comb begin
        win_t work [NUM_SRC];
        work = leaf;
        for (int l = 0; l < LEVELS; l++) begin
            for (int k = 0; k < (NUM_SRC >> (l + 1)); k++) begin
                work[k] = pick(work[2*k], work[2*k+1]);
            end
        end
        best = work[0];
    end

endmodule

// File: rtl/thresh_gate.sv
module thresh_gate
    import prio_arb_pkg::*;
(
    input  win_t              best,
    input  logic [MASK_W-1:0] mask_lvl,
    output logic              irq_d
);

    logic gate_off;
    logic above;

    assign gate_off = (mask_lvl == MASK_OFF);
    assign above    = (MASK_W'(best.prio) > mask_lvl);
    // the best priority exceeds the mask iff some active priority does
    assign irq_d    = best.valid && (gate_off || above);

endmodule

// File: rtl/status_fmt.sv
module status_fmt
    import prio_arb_pkg::*;
(
    input  win_t              win,
    output logic [WORD_W-1:0] word
);

    always_comb begin
        if (win.valid) begin
            word = '0;
            word[WORD_W-1:SRC_LSB] = SRC_FLD'(win.src);
            word[PRIO_W-1:0]       = win.prio;
        end else begin
            word = NO_WINNER;
        end
    end

endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
    import prio_arb_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_SRC-1:0]         req_vec,
    input  logic [NUM_SRC*PRIO_W-1:0]  prio_flat,
    input  logic [MASK_W-1:0]          mask_lvl,
    input  logic                       rd_stb,
    output logic                       irq_out,
    output logic [WORD_W-1:0]          status_word,
    output logic                       ack_valid,
    output logic [SRC_W-1:0]           ack_src
);

    win_t              win_d;
    win_t              win_q;
    logic              irq_d;
    logic              irq_q;
    logic [WORD_W-1:0] status_d;
    logic [WORD_W-1:0] status_q;

    prio_tree u_tree (
        .req       (req_vec),
        .prio_flat (prio_flat),
        .best      (win_d)
    );

    thresh_gate u_gate (
        .best     (win_d),
        .mask_lvl (mask_lvl),
        .irq_d    (irq_d)
    );

    status_fmt u_fmt (
        .win  (win_q),
        .word (status_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q    <= '0;
            irq_q    <= 1'b0;
            status_q <= NO_WINNER;
        end else begin
            win_q <= win_d;
            irq_q <= irq_d;
            if (rd_stb)
                status_q <= status_d;
        end
    end

    assign irq_out     = irq_q;
    assign status_word = status_q;
    assign ack_valid   = rd_stb && win_q.valid;
    assign ack_src     = win_q.src;

endmodule

// File: rtl/prio_irq_arbiter_chk.sv
module prio_irq_arbiter_chk
    import prio_arb_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [NUM_SRC-1:0]  req_vec,
    input logic [MASK_W-1:0]   mask_lvl,
    input logic                rd_stb,
    input logic                irq_out,
    input logic [WORD_W-1:0]   status_word,
    input logic                ack_valid,
    input logic [SRC_W-1:0]    ack_src
);

    p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
        !(|req_vec) |=> !irq_out);

    p_gate_off_r3: assert property (@(posedge clk) disable iff (rst)
        ((|req_vec) && mask_lvl == MASK_OFF) |=> irq_out);

    p_high_mask_r4: assert property (@(posedge clk) disable iff (rst)
        (mask_lvl > MASK_W'(15) && mask_lvl != MASK_OFF) |=> !irq_out);

    p_ack_in_read_r9: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> rd_stb);

    p_word_layout_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && ack_valid) |=>
            (status_word[SRC_LSB-1:PRIO_W] == '0 &&
             status_word[WORD_W-1:SRC_LSB] == SRC_FLD'($past(ack_src))));

    p_empty_word_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !ack_valid) |=> status_word == NO_WINNER);

    p_word_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> $stable(status_word));

endmodule

bind prio_irq_arbiter prio_irq_arbiter_chk u_chk (.*);

// File: tb/prio_irq_arbiter_tb.sv
module prio_irq_arbiter_tb;
    import prio_arb_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                       rst;
    logic [NUM_SRC-1:0]         req_vec;
    logic [NUM_SRC*PRIO_W-1:0]  prio_flat;
    logic [MASK_W-1:0]          mask_lvl;
    logic                       rd_stb;
    logic                       irq_out;
    logic [WORD_W-1:0]          status_word;
    logic                       ack_valid;
    logic [SRC_W-1:0]           ack_src;

    prio_irq_arbiter u_dut (
        .clk         (clk),
        .rst         (rst),
        .req_vec     (req_vec),
        .prio_flat   (prio_flat),
        .mask_lvl    (mask_lvl),
        .rd_stb      (rd_stb),
        .irq_out     (irq_out),
        .status_word (status_word),
        .ack_valid   (ack_valid),
        .ack_src     (ack_src)
    );

    int n_chk  = 0;
    int n_fail = 0;
    logic [WORD_W-1:0] exp_q [$];
    string             tag_q [$];
    logic rd_d = 1'b0;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // reference model written from the requirements
    function automatic logic [6:0] model_win(input logic [NUM_SRC-1:0] r,
                                             input logic [NUM_SRC*PRIO_W-1:0] p);
        logic found = 1'b0;
        int   bs = 0;
        int   bp = 0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (r[i] && (!found || int'(p[i*PRIO_W +: PRIO_W]) >= bp)) begin
                found = 1'b1;
                bs = i;
                bp = int'(p[i*PRIO_W +: PRIO_W]);
            end
        end
        return {found, 6'(bs)};
    endfunction

    function automatic logic model_irq(input logic [NUM_SRC-1:0] r,
                                       input logic [NUM_SRC*PRIO_W-1:0] p,
                                       input logic [MASK_W-1:0] m);
        logic any = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (r[i] && (m == 5'h1F || int'(p[i*PRIO_W +: PRIO_W]) > int'(m)))
                any = 1'b1;
        end
        return any;
    endfunction

    // driver: change inputs, check latency and the new line state
    task automatic apply(input logic [NUM_SRC-1:0] r,
                         input logic [NUM_SRC*PRIO_W-1:0] p,
                         input logic [MASK_W-1:0] m, input string tag);
        logic old_irq;
        old_irq = model_irq(req_vec, prio_flat, mask_lvl);
        req_vec   = r;
        prio_flat = p;
        mask_lvl  = m;
        #1;
        chk(irq_out === old_irq, "R10 irq before edge", 32'(irq_out), 32'(old_irq));
        @(posedge clk);
        @(negedge clk);
        chk(irq_out === model_irq(r, p, m), tag, 32'(irq_out), 32'(model_irq(r, p, m)));
    endtask

    // driver: one vector read; bench plays the register block and clears the bit
    task automatic do_read(input string tag);
        logic [6:0]        w;
        logic [WORD_W-1:0] word;
        int                wp;
        w = model_win(req_vec, prio_flat);
        wp = int'(prio_flat[int'(w[5:0])*PRIO_W +: PRIO_W]);
        word = w[6] ? {16'(w[5:0]), 12'h000, 4'(wp)} : 32'hFFFF_FFFF;
        rd_stb = 1'b1;
        #1;
        chk(ack_valid === w[6], {"R9 ack_valid ", tag}, 32'(ack_valid), 32'(w[6]));
        if (w[6])
            chk(ack_src === w[5:0], {"R9 ack_src ", tag}, 32'(ack_src), 32'(w[5:0]));
        exp_q.push_back(word);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_stb = 1'b0;
        if (w[6])
            req_vec[w[5:0]] = 1'b0;
        #1;
        chk(ack_valid === 1'b0, "R9 ack one cycle", 32'(ack_valid), 32'h0);
        @(posedge clk);
        @(negedge clk);
        chk(irq_out === model_irq(req_vec, prio_flat, mask_lvl), "R10 irq after clear",
            32'(irq_out), 32'(model_irq(req_vec, prio_flat, mask_lvl)));
    endtask

    // monitor: compare the captured word one cycle after each strobe
    always @(posedge clk) rd_d <= rd_stb;
    always @(negedge clk) begin
        if (rd_d) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected read", status_word, 32'h0);
            end else begin
                logic [WORD_W-1:0] e;
                string             t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(status_word === e, {"R7 R8 status ", t}, status_word, e);
            end
        end
    end

    function automatic logic [NUM_SRC*PRIO_W-1:0] set_p(
        input logic [NUM_SRC*PRIO_W-1:0] p, input int idx, input int val);
        logic [NUM_SRC*PRIO_W-1:0] q;
        q = p;
        q[idx*PRIO_W +: PRIO_W] = 4'(val);
        return q;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'h0, 32'h1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [NUM_SRC*PRIO_W-1:0] p;
        logic [NUM_SRC-1:0]        r;
        int                        guard;
        rst = 1'b1; req_vec = '0; prio_flat = '0; mask_lvl = 5'h1F; rd_stb = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(irq_out === 1'b0, "R1 irq reset", 32'(irq_out), 32'h0);
        chk(status_word === 32'hFFFF_FFFF, "R1 status reset", status_word, 32'hFFFF_FFFF);
        chk(ack_valid === 1'b0, "R1 ack reset", 32'(ack_valid), 32'h0);
        @(negedge clk);

        // R2 and R8: nothing active
        apply('0, '0, 5'd0, "R2 idle mask 0");
        do_read("R8 empty");

        // R3: gating off, priority 0
        p = '0;
        r = '0; r[5] = 1'b1;
        apply(r, p, 5'h1F, "R3 mask off prio 0");
        // R4: strict comparison
        p = set_p(p, 5, 3);
        apply(r, p, 5'd3, "R4 equal not above");
        p = set_p(p, 5, 4);
        apply(r, p, 5'd3, "R4 above");
        p = set_p(p, 5, 15);
        apply(r, p, 5'd20, "R4 mask 20 blocks");
        apply(r, p, 5'd16, "R4 mask 16 blocks");

        // R5: distinct priorities read in descending order
        p = '0; r = '0;
        r[2] = 1'b1;  p = set_p(p, 2, 7);
        r[17] = 1'b1; p = set_p(p, 17, 12);
        r[50] = 1'b1; p = set_p(p, 50, 1);
        apply(r, p, 5'd0, "R5 setup");
        do_read("R5 first");
        do_read("R5 second");
        do_read("R5 third");
        do_read("R8 drained");

        // R6: ties go to the highest number
        p = '0; r = '0;
        r[0] = 1'b1;  p = set_p(p, 0, 9);
        r[3] = 1'b1;  p = set_p(p, 3, 9);
        r[40] = 1'b1; p = set_p(p, 40, 9);
        r[63] = 1'b1; p = set_p(p, 63, 9);
        r[62] = 1'b1; p = set_p(p, 62, 8);
        apply(r, p, 5'h1F, "R6 setup");
        for (int k = 0; k < 6; k++) do_read("R6 tie");

        // R5 R6 R4: random patterns, drained fully
        for (int round = 0; round < 24; round++) begin
            for (int w = 0; w < NUM_SRC * PRIO_W / 32; w++)
                p[w*32 +: 32] = $urandom();
            r = {$urandom(), $urandom()} & {$urandom(), $urandom()};
            apply(r, p, 5'($urandom_range(0, 31)), "R4 random");
            guard = 0;
            while (req_vec != '0 && guard < 70) begin
                do_read("R5 random");
                guard++;
            end
            do_read("R8 random empty");
        end

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R7 queue drained", 32'(exp_q.size()), 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule